// File: doc/BRIEF.md
# Prescaled Slow-Clock Tick Counter

This block is a low-power elapsed-time counter clocked by a slow clock. A 16-bit divider produces one roll-over event every programmed number of slow-clock cycles, and a 32-bit counter advances on each roll-over. Instead of roll-overs, the counter can be driven by an external once-per-second tick that is edge-detected in the slow-clock domain.

Software reaches four 32-bit words through a simple single-cycle port. The mode word holds the divider period, the counter source, a halt bit, a self-clearing restart strobe and two interrupt enables. Writes to the mode word are blocked while the write-protect input is high. The alarm word is compared against the counter, the value word returns the counter, and the status word holds an increment flag and an alarm flag. Reading the status word clears both flags. A single interrupt output combines each flag with its enable.

Read data is combinational from the address. Writes and read side effects take place on the rising clock edge that samples the strobe.

Top module: `slow_tick_timer`

## Requirements
- R1: After reset the mode word (address 0) reads 0x00008000, the alarm word (address 1) reads 0xFFFFFFFF, and the value word (address 2), the status word (address 3) and irq are all 0.
- R2: With mode bits 15:0 = N (N ≥ 3) and the roll-over source selected, the counter read at address 2 advances by one every N slow-clock cycles. Address 2 is read-only.
- R3: A divider field of 0 gives one increment every 65536 cycles.
- R4: Divider fields 1 and 2 run as a period of 3 cycles, and the field reads back as written.
- R5: With mode bit 24 set, the counter advances once per rising edge of tick_1hz. A tick held high counts only once, and divider roll-overs do not count.
- R6: With mode bit 20 set, the divider and the counter hold their values and tick edges are ignored.
- R7: Writing mode bit 18 = 1 clears the counter and the divider on that edge, so the new period runs from a fresh start. Bit 18 always reads 0. A restart takes effect even when bit 20 is set.
- R8: While wp_en is high, writes to the mode word have no effect, and that includes the restart.
- R9: Status bit 0 (alarm flag) is set on the increment that makes the counter equal to the alarm word.
- R10: Status bit 1 (increment flag) is set on every counter increment. A status read clears both flags, but a flag that is set in the same cycle stays set.
- R11: irq is high exactly when (status bit 0 AND mode bit 16) OR (status bit 1 AND mode bit 17).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_en | input | 1 | Blocks writes to the mode word when high |
| tick_1hz | input | 1 | External once-per-second tick, synchronous to clk |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; reading the status word clears the flags |
| reg_addr | input | 2 | Word select: 0 mode, 1 alarm, 2 value, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following: the divider steps by one or reloads, the counter changes by at most one between restarts, the counter freezes while halted, a restart zeroes both the divider and the counter, the status read clear works, and a protected write leaves the mode unchanged. Some behaviour only the bench can show, because it depends on end-to-end periods counted over many cycles. That covers the exact period for a general value, for zero and for the forbidden values; one count per held tick; the moment the alarm flag appears relative to the counter value; and the interrupt combination under random mixes of writes, reads and ticks.

// File: rtl/stt_pkg.sv
package stt_pkg;

    localparam int PRE_W  = 16;
    localparam int CNT_W  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    // Mode word bit positions
    localparam int B_ALM_IE  = 16;
    localparam int B_INC_IE  = 17;
    localparam int B_RESTART = 18;
    localparam int B_HALT    = 20;
    localparam int B_SRC     = 24;

    localparam logic [DATA_W-1:0] MODE_RST  = 32'h0000_8000;
    localparam logic [CNT_W-1:0]  ALARM_RST = '1;
    localparam logic [PRE_W-1:0]  MIN_PM1   = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE   = 2'd0,
        A_ALARM  = 2'd1,
        A_VALUE  = 2'd2,
        A_STATUS = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             src_tick;
        logic             halt;
        logic             inc_ie;
        logic             alm_ie;
        logic [PRE_W-1:0] presc;
    } mode_t;

    typedef struct packed {
        logic inc;
        logic alarm;
    } flags_t;

    function automatic mode_t unpack_mode(input logic [DATA_W-1:0] w);
        mode_t m;
        m.src_tick = w[B_SRC];
        m.halt     = w[B_HALT];
        m.inc_ie   = w[B_INC_IE];
        m.alm_ie   = w[B_ALM_IE];
        m.presc    = w[PRE_W-1:0];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] pack_mode(input mode_t m);
        logic [DATA_W-1:0] w;
        w              = '0;
        w[B_SRC]       = m.src_tick;
        w[B_HALT]      = m.halt;
        w[B_INC_IE]    = m.inc_ie;
        w[B_ALM_IE]    = m.alm_ie;
        w[PRE_W-1:0]   = m.presc;
        return w;
    endfunction

    // Last divider count before roll-over: 0 -> full range, 1/2 -> clamp to 3
    function automatic logic [PRE_W-1:0] period_m1(input logic [PRE_W-1:0] p);
        if (p == '0)
            return '1;
        else if (p <= MIN_PM1)
            return MIN_PM1;
        else
            return p - 1'b1;
    endfunction

endpackage

// File: rtl/stt_prescaler.sv
module stt_prescaler #(
    parameter int W = stt_pkg::PRE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         restart,
    input  logic [W-1:0] last_cnt,
    output logic         roll
);
    logic [W-1:0] div_q;

    assign roll = enable && !restart && (div_q == last_cnt);

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (restart)
            div_q <= '0;
        else if (enable)
            div_q <= roll ? '0 : div_q + 1'b1;
    end

    a_r2_div_step: assert property (@(posedge clk) disable iff (rst)
        (enable && !restart && div_q != last_cnt) |=> div_q == $past(div_q) + 1'b1);

    a_r7_div_reload: assert property (@(posedge clk) disable iff (rst)
        restart |=> div_q == '0);

    a_r6_div_hold: assert property (@(posedge clk) disable iff (rst)
        (!enable && !restart) |=> $stable(div_q));

    a_r4_min_period: assert property (@(posedge clk) disable iff (rst)
        last_cnt >= W'(2));

endmodule

// File: rtl/stt_counter.sv
module stt_counter #(
    parameter int W = stt_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         restart,
    input  logic         use_tick,
    input  logic         tick_in,
    input  logic         roll,
    input  logic [W-1:0] alarm_val,
    output logic [W-1:0] count,
    output logic         inc_ev,
    output logic         alarm_hit
);
    logic         tick_d;
    logic         tick_rise;
    logic [W-1:0] count_nx;

    assign tick_rise = tick_in && !tick_d;
    assign inc_ev    = enable && !restart && (use_tick ? tick_rise : roll);
    assign count_nx  = count + 1'b1;
    assign alarm_hit = inc_ev && (count_nx == alarm_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_d <= 1'b0;
            count  <= '0;
        end else begin
            tick_d <= tick_in;
            if (restart)
                count <= '0;
            else if (inc_ev)
                count <= count_nx;
        end
    end

    a_r7_count_clear: assert property (@(posedge clk) disable iff (rst)
        restart |=> count == '0);

    a_r6_count_freeze: assert property (@(posedge clk) disable iff (rst)
        (!enable && !restart) |=> $stable(count));

    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        !restart |=> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

// File: rtl/stt_status.sv
module stt_status (
    input  logic            clk,
    input  logic            rst,
    input  logic            inc_set,
    input  logic            alm_set,
    input  logic            clr,
    input  logic            inc_ie,
    input  logic            alm_ie,
    output stt_pkg::flags_t flags,
    output logic            irq
);
    import stt_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.inc   <= inc_set || (flags.inc   && !clr);
            flags.alarm <= alm_set || (flags.alarm && !clr);
        end
    end

    assign irq = (flags.alarm && alm_ie) || (flags.inc && inc_ie);

    a_r10_read_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !inc_set) |=> !flags.inc);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        inc_set |=> flags.inc);

    a_r9_alarm_set: assert property (@(posedge clk) disable iff (rst)
        alm_set |=> flags.alarm);

endmodule

// File: rtl/slow_tick_timer.sv
module slow_tick_timer (
    input  logic        clk,
    input  logic        rst,
    input  logic        wp_en,
    input  logic        tick_1hz,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    import stt_pkg::*;

    mode_t             mode_q;
    logic [CNT_W-1:0]  alarm_q;
    logic [CNT_W-1:0]  count;
    logic [PRE_W-1:0]  last_cnt;
    logic              wr_mode, restart, st_clr, enable;
    logic              roll, inc_ev, alarm_hit;
    flags_t            flags;
    reg_addr_e         addr;

    assign addr     = reg_addr_e'(reg_addr);
    assign wr_mode  = reg_wr && (addr == A_MODE) && !wp_en;
    assign restart  = wr_mode && reg_wdata[B_RESTART];
    assign st_clr   = reg_rd && (addr == A_STATUS);
    assign enable   = !mode_q.halt;
    assign last_cnt = period_m1(mode_q.presc);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= unpack_mode(MODE_RST);
            alarm_q <= ALARM_RST;
        end else begin
            if (wr_mode)
                mode_q <= unpack_mode(reg_wdata);
            if (reg_wr && addr == A_ALARM)
                alarm_q <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (addr)
            A_MODE:   reg_rdata = pack_mode(mode_q);
            A_ALARM:  reg_rdata = alarm_q;
            A_VALUE:  reg_rdata = count;
            A_STATUS: reg_rdata[1:0] = flags;
            default:  reg_rdata = '0;
        endcase
    end

    stt_prescaler #(.W(PRE_W)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .restart  (restart),
        .last_cnt (last_cnt),
        .roll     (roll)
    );

    stt_counter #(.W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .restart   (restart),
        .use_tick  (mode_q.src_tick),
        .tick_in   (tick_1hz),
        .roll      (roll),
        .alarm_val (alarm_q),
        .count     (count),
        .inc_ev    (inc_ev),
        .alarm_hit (alarm_hit)
    );

    stt_status u_status (
        .clk     (clk),
        .rst     (rst),
        .inc_set (inc_ev),
        .alm_set (alarm_hit),
        .clr     (st_clr),
        .inc_ie  (mode_q.inc_ie),
        .alm_ie  (mode_q.alm_ie),
        .flags   (flags),
        .irq     (irq)
    );

    a_r8_protect: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && addr == A_MODE && wp_en) |=> $stable(mode_q));

endmodule

// File: tb/slow_tick_timer_tb.sv
`timescale 1ns/1ps
module slow_tick_timer_tb;
    logic        clk = 0, rst = 1, wp_en = 0, tick_1hz = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [1:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq;

    localparam logic [31:0] RST_BIT = 32'h0004_0000;
    localparam logic [31:0] HALT    = 32'h0010_0000;
    localparam logic [31:0] SRC     = 32'h0100_0000;
    localparam logic [31:0] AIE     = 32'h0001_0000;
    localparam logic [31:0] IIE     = 32'h0002_0000;
    localparam logic [31:0] MASK    = 32'h0113_FFFF;

    int checks = 0, fails = 0;
    bit done = 0;

    slow_tick_timer u_dut (.*);

    always #5 clk = ~clk;

    // Reference model, updated from pre-edge values
    logic [31:0] m_mode, m_alarm, m_cnt;
    logic [15:0] m_div;
    logic [1:0]  m_flags;
    logic        m_tick_d;

    function automatic logic [15:0] ref_last(input logic [15:0] p);
        if (p == 0) return 16'hFFFF;
        if (p < 3)  return 16'd2;
        return p - 16'd1;
    endfunction

    always @(posedge clk) begin : model
        logic en, wm, rs, roll, rise, inc, ahit, clr;
        logic [15:0] lc;
        if (rst) begin
            m_mode = 32'h0000_8000; m_alarm = 32'hFFFF_FFFF; m_cnt = 0;
            m_div = 0; m_flags = 0; m_tick_d = 0;
        end else begin
            en   = !m_mode[20];
            wm   = reg_wr && reg_addr == 2'd0 && !wp_en;
            rs   = wm && reg_wdata[18];
            lc   = ref_last(m_mode[15:0]);
            roll = en && m_div == lc;
            rise = tick_1hz && !m_tick_d;
            inc  = en && !rs && (m_mode[24] ? rise : roll);
            ahit = inc && (m_cnt + 1 == m_alarm);
            clr  = reg_rd && reg_addr == 2'd3;
            m_flags[1] = inc  || (m_flags[1] && !clr);
            m_flags[0] = ahit || (m_flags[0] && !clr);
            if (rs) m_div = 0; else if (en) m_div = roll ? 16'd0 : m_div + 16'd1;
            if (rs) m_cnt = 0; else if (inc) m_cnt = m_cnt + 1;
            if (reg_wr && reg_addr == 2'd1) m_alarm = reg_wdata;
            if (wm) m_mode = reg_wdata & MASK;
            m_tick_d = tick_1hz;
        end
    end

    function automatic logic [31:0] ref_read(input logic [1:0] a);
        case (a)
            2'd0: return m_mode;
            2'd1: return m_alarm;
            2'd2: return m_cnt;
            default: return {30'd0, m_flags};
        endcase
    endfunction

    function automatic logic ref_irq();
        return (m_flags[0] && m_mode[16]) || (m_flags[1] && m_mode[17]);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        reg_rd = 0; reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic rd_status(output logic [31:0] d);
        reg_rd = 1; reg_addr = 2'd3; #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4711));
        step(3);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, d); chk("R1 mode", d, 32'h0000_8000);
        peek(2'd1, d); chk("R1 alarm", d, 32'hFFFF_FFFF);
        peek(2'd2, d); chk("R1 value", d, 0);
        peek(2'd3, d); chk("R1 status", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 period 5
        wr_reg(2'd0, 32'd5 | RST_BIT);
        step(4); peek(2'd2, d); chk("R2 before", d, 0);
        step(1); peek(2'd2, d); chk("R2 first", d, 1);
        step(5); peek(2'd2, d); chk("R2 second", d, 2);
        wr_reg(2'd2, 32'h55); peek(2'd2, d); chk("R2 readonly", d, 2);

        // R3 zero -> 65536
        wr_reg(2'd0, 32'd0 | RST_BIT);
        step(65535); peek(2'd2, d); chk("R3 before", d, 0);
        step(1);     peek(2'd2, d); chk("R3 first", d, 1);

        // R4 forbidden value runs as 3
        wr_reg(2'd0, 32'd1 | RST_BIT);
        step(2); peek(2'd2, d); chk("R4 before", d, 0);
        step(1); peek(2'd2, d); chk("R4 first", d, 1);
        step(3); peek(2'd2, d); chk("R4 second", d, 2);
        peek(2'd0, d); chk("R4 readback", d, 32'd1);

        // R7 restart mid-run
        wr_reg(2'd0, 32'd3 | RST_BIT);
        peek(2'd2, d); chk("R7 cleared", d, 0);
        peek(2'd0, d); chk("R7 strobe reads 0", d, 32'd3);
        step(2); peek(2'd2, d); chk("R7 reload before", d, 0);
        step(1); peek(2'd2, d); chk("R7 reload first", d, 1);

        // R6 halt
        wr_reg(2'd0, 32'd3 | HALT | SRC | RST_BIT);
        for (int i = 0; i < 3; i++) begin tick_1hz = 1; step(2); tick_1hz = 0; step(2); end
        step(10); peek(2'd2, d); chk("R6 frozen", d, 0);
        wr_reg(2'd0, 32'd3);
        step(2); peek(2'd2, d); chk("R6 resume before", d, 0);
        step(1); peek(2'd2, d); chk("R6 resume first", d, 1);

        // R5 tick source
        wr_reg(2'd0, SRC | 32'd3 | RST_BIT);
        for (int i = 0; i < 4; i++) begin tick_1hz = 1; step(3); tick_1hz = 0; step(2); end
        peek(2'd2, d); chk("R5 tick count", d, 4);

        // R8 write protect
        wp_en = 1;
        wr_reg(2'd0, 32'd7 | RST_BIT);
        peek(2'd0, d); chk("R8 mode kept", d, SRC | 32'd3);
        peek(2'd2, d); chk("R8 no restart", d, 4);
        wp_en = 0;

        // R9 R10 R11 alarm and flags
        wr_reg(2'd1, 32'd3);
        wr_reg(2'd0, 32'd4 | AIE | RST_BIT);
        rd_status(d);
        step(10); peek(2'd2, d); chk("R9 pre", d, 2);
        chk("R11 inc not enabled", {31'd0, irq}, 0);
        step(1); peek(2'd2, d); chk("R9 at alarm", d, 3);
        chk("R11 alarm irq", {31'd0, irq}, 1);
        rd_status(d); chk("R9 R10 flags", d, 32'd3);
        chk("R10 irq dropped", {31'd0, irq}, 0);
        rd_status(d); chk("R10 cleared", d, 0);

        // Random mix checked against the model
        for (int c = 0; c < 4000; c++) begin
            logic [31:0] w;
            logic [1:0] a;
            string tag;
            wp_en    = ($urandom % 10) == 0;
            tick_1hz = ($urandom % 3) == 0;
            reg_rd   = ($urandom % 8) == 0;
            reg_wr   = ($urandom % 16) == 0;
            a        = 2'($urandom % 4);
            reg_addr = a;
            if (a == 2'd0) begin
                w = 32'd3 + ($urandom % 10);
                if ($urandom % 2) w |= AIE;
                if ($urandom % 2) w |= IIE;
                if ($urandom % 3 == 0) w |= RST_BIT;
                if ($urandom % 7 == 0) w |= HALT;
                if ($urandom % 3 == 0) w |= SRC;
                reg_wdata = w;
            end else begin
                reg_wdata = $urandom % 16;
            end
            #1;
            case (a)
                2'd0: tag = "R8 rand mode";
                2'd1: tag = "R9 rand alarm";
                2'd2: tag = "R2 rand value";
                default: tag = "R10 rand status";
            endcase
            chk(tag, reg_rdata, ref_read(a));
            chk("R11 rand irq", {31'd0, irq}, {31'd0, ref_irq()});
            @(posedge clk); @(negedge clk);
        end
        reg_wr = 0; reg_rd = 0; wp_en = 0; tick_1hz = 0;
        summary();
    end
endmodule